// File: doc/BRIEF.md
# Privilege Mode Return Controller

This block keeps the hart's current privilege level (user, supervisor or machine) together with the status bits that trap entry and trap return act on. These are the two global interrupt enables, their saved copies, the two previous-privilege fields, and the modify-privilege bit. The modify-privilege bit makes loads and stores run with the saved machine previous privilege.

The pipeline sends three kinds of one-cycle request:
- a machine return;
- a supervisor return;
- a trap entry with a target level.

The block applies the request on the next rising clock edge. Software can also load the status bits through a write port. Before they are stored, the previous-privilege fields are made legal. A return that takes the hart out of machine mode also clears the modify-privilege bit. This stops a lower-privileged mode from inheriting an effective-privilege override.

Top module: `priv_ret_ctrl`

## Requirements
- R1: After reset the outputs are:
  - level machine (`mode_o` = 2'b11), where level codes are user 2'b00, supervisor 2'b01, machine 2'b11;
  - both interrupt enables and both saved enables 0;
  - modify-privilege 0;
  - machine previous level user (2'b00);
  - supervisor previous level 0.
- R2: A machine return updates three things on the next edge:
  - the level becomes the machine previous level;
  - the machine enable takes the saved machine enable;
  - the saved machine enable becomes 1.
- R3: A machine return sets the machine previous level to user, or to machine when user mode is not built in.
- R4: The effect of a machine return on the modify-privilege bit depends on the machine previous level held at the return:
  - if that level is not machine, the return clears the bit;
  - if that level is machine, the return leaves the bit unchanged.
- R5: A supervisor return does all of the following:
  - the level becomes supervisor if the supervisor previous level is 1, and user if it is 0;
  - the supervisor enable takes the saved supervisor enable;
  - the saved supervisor enable becomes 1;
  - the supervisor previous level becomes 0;
  - the modify-privilege bit is cleared.
- R6: A trap entry to level x (`trap_mode_i` 2'b11 for machine, 2'b01 for supervisor) does all of the following:
  - the saved x enable takes the x enable;
  - the x enable is cleared;
  - the x previous level records the level before the trap; for supervisor it is 1 unless that level was user;
  - the level becomes x.
- R7: A status write takes its fields from `csr_wdata_i` at these bits:
  - bit 0: supervisor enable;
  - bit 1: machine enable;
  - bit 2: saved supervisor enable;
  - bit 3: saved machine enable;
  - bit 4: supervisor previous level;
  - bits 6:5: machine previous level;
  - bit 7: modify-privilege.
  A write of the reserved code 2'b10, or of an unbuilt level, leaves the machine previous level unchanged. A status write never changes the current level.
- R8: A trap entry in the same cycle as a return takes effect, and the return is dropped.
- R9: A return in the same cycle as a status write takes effect, and the write is dropped.
- R10: A machine return in the same cycle as a supervisor return takes effect as a machine return only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mret_i | input | 1 | One-cycle machine return request |
| sret_i | input | 1 | One-cycle supervisor return request |
| trap_i | input | 1 | One-cycle trap entry request |
| trap_mode_i | input | 2 | Target level of the trap entry |
| csr_we_i | input | 1 | Status register write strobe |
| csr_wdata_i | input | 8 | Status write data, layout in R7 |
| mode_o | output | 2 | Current privilege level |
| mie_o | output | 1 | Machine interrupt enable |
| mpie_o | output | 1 | Saved machine interrupt enable |
| mpp_o | output | 2 | Machine previous level |
| sie_o | output | 1 | Supervisor interrupt enable |
| spie_o | output | 1 | Saved supervisor interrupt enable |
| spp_o | output | 1 | Supervisor previous level |
| mprv_o | output | 1 | Modify-privilege bit |

## Verification
The assertions assume the following about the inputs:
- every request is a single-cycle pulse that is sampled only after the internal reset has been released;
- a trap entry targets only machine or supervisor;
- a return arrives only when the pipeline has already judged it legal for the current level.

The stimulus respects all of these. Each request is raised for exactly one cycle, starting at a falling edge and a few cycles after reset release. A trap always carries code 2'b11 or 2'b01. The collision cases are the only places where two requests share a cycle.

// File: rtl/prv_pkg.sv
package prv_pkg;

  localparam logic [1:0] PRV_U   = 2'b00;
  localparam logic [1:0] PRV_S   = 2'b01;
  localparam logic [1:0] PRV_RSV = 2'b10;
  localparam logic [1:0] PRV_M   = 2'b11;

  localparam int unsigned CSR_W     = 8;
  localparam int unsigned BIT_SIE   = 0;
  localparam int unsigned BIT_MIE   = 1;
  localparam int unsigned BIT_SPIE  = 2;
  localparam int unsigned BIT_MPIE  = 3;
  localparam int unsigned BIT_SPP   = 4;
  localparam int unsigned BIT_MPP   = 5;
  localparam int unsigned BIT_MPRV  = 7;

  typedef struct packed {
    logic [1:0] mode;
    logic       mprv;
    logic [1:0] mpp;
    logic       spp;
    logic       mpie;
    logic       spie;
    logic       mie;
    logic       sie;
  } prv_state_t;

endpackage

// File: rtl/prv_rst_sync.sv
module prv_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  localparam int unsigned LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic [LAST:0] chain_d;

  generate
    if (STAGES > 1) begin : g_multi
      always_comb chain_d = {chain_q[LAST-1:0], 1'b1};
    end else begin : g_single
      always_comb chain_d = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[LAST];
endmodule

// File: rtl/prv_pp_legal.sv
module prv_pp_legal
  import prv_pkg::*;
#(
  parameter bit HAS_U = 1'b1,
  parameter bit HAS_S = 1'b1
) (
  input  logic [1:0] wr_mpp,
  input  logic [1:0] cur_mpp,
  input  logic       wr_spp,
  input  logic       wr_mprv,
  output logic [1:0] mpp_q,
  output logic       spp_q,
  output logic       mprv_q
);
  logic mpp_ok;

  always_comb begin
    unique case (wr_mpp)
      PRV_M:   mpp_ok = 1'b1;
      PRV_S:   mpp_ok = HAS_S;
      PRV_U:   mpp_ok = HAS_U;
      default: mpp_ok = 1'b0;
    endcase
    mpp_q = mpp_ok ? wr_mpp : cur_mpp;
  end

  generate
    if (HAS_U) begin : g_user
      assign mprv_q = wr_mprv;
      assign spp_q  = HAS_S ? wr_spp : 1'b0;
    end else begin : g_no_user
      assign mprv_q = 1'b0;
      assign spp_q  = HAS_S;
    end
  endgenerate
endmodule

// File: rtl/prv_next.sv
module prv_next
  import prv_pkg::*;
#(
  parameter bit HAS_U = 1'b1,
  parameter bit HAS_S = 1'b1
) (
  input  prv_state_t       cur,
  input  logic             mret,
  input  logic             sret,
  input  logic             trap,
  input  logic [1:0]       trap_mode,
  input  logic             csr_we,
  input  logic [CSR_W-1:0] csr_wdata,
  output prv_state_t       nxt,
  output logic             load_en
);
  localparam logic [1:0] PP_IDLE = HAS_U ? PRV_U : PRV_M;

  logic       sret_eff;
  logic [1:0] trap_tgt;
  logic [1:0] lg_mpp;
  logic       lg_spp;
  logic       lg_mprv;

  prv_pp_legal #(.HAS_U(HAS_U), .HAS_S(HAS_S)) u_legal (
    .wr_mpp  (csr_wdata[BIT_MPP +: 2]),
    .cur_mpp (cur.mpp),
    .wr_spp  (csr_wdata[BIT_SPP]),
    .wr_mprv (csr_wdata[BIT_MPRV]),
    .mpp_q   (lg_mpp),
    .spp_q   (lg_spp),
    .mprv_q  (lg_mprv)
  );

  assign sret_eff = sret & HAS_S;
  assign trap_tgt = (HAS_S && trap_mode == PRV_S) ? PRV_S : PRV_M;
  assign load_en  = trap | mret | sret_eff | csr_we;

  always_comb begin
    nxt = cur;
    if (trap) begin
      if (trap_tgt == PRV_M) begin
        nxt.mpie = cur.mie;
        nxt.mie  = 1'b0;
        nxt.mpp  = cur.mode;
        nxt.mode = PRV_M;
      end else begin
        nxt.spie = cur.sie;
        nxt.sie  = 1'b0;
        nxt.spp  = (cur.mode != PRV_U);
        nxt.mode = PRV_S;
      end
    end else if (mret) begin
      nxt.mode = cur.mpp;
      nxt.mie  = cur.mpie;
      nxt.mpie = 1'b1;
      nxt.mpp  = PP_IDLE;
      if (cur.mpp != PRV_M) nxt.mprv = 1'b0;
    end else if (sret_eff) begin
      nxt.mode = cur.spp ? PRV_S : PRV_U;
      nxt.sie  = cur.spie;
      nxt.spie = 1'b1;
      nxt.spp  = 1'b0;
      nxt.mprv = 1'b0;
    end else if (csr_we) begin
      nxt.mie  = csr_wdata[BIT_MIE];
      nxt.mpie = csr_wdata[BIT_MPIE];
      nxt.sie  = HAS_S & csr_wdata[BIT_SIE];
      nxt.spie = HAS_S & csr_wdata[BIT_SPIE];
      nxt.spp  = lg_spp;
      nxt.mpp  = lg_mpp;
      nxt.mprv = lg_mprv;
    end
  end
endmodule

// File: rtl/priv_ret_ctrl.sv
module priv_ret_ctrl
  import prv_pkg::*;
#(
  parameter bit          HAS_U       = 1'b1,
  parameter bit          HAS_S       = 1'b1,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mret_i,
  input  logic             sret_i,
  input  logic             trap_i,
  input  logic [1:0]       trap_mode_i,
  input  logic             csr_we_i,
  input  logic [CSR_W-1:0] csr_wdata_i,
  output logic [1:0]       mode_o,
  output logic             mie_o,
  output logic             mpie_o,
  output logic [1:0]       mpp_o,
  output logic             sie_o,
  output logic             spie_o,
  output logic             spp_o,
  output logic             mprv_o
);
  localparam logic [1:0] PP_IDLE = HAS_U ? PRV_U : PRV_M;

  logic       rst_sync_n;
  prv_state_t state_q;
  prv_state_t state_d;
  logic       state_en;

  prv_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  prv_next #(.HAS_U(HAS_U), .HAS_S(HAS_S)) u_next (
    .cur       (state_q),
    .mret      (mret_i),
    .sret      (sret_i),
    .trap      (trap_i),
    .trap_mode (trap_mode_i),
    .csr_we    (csr_we_i),
    .csr_wdata (csr_wdata_i),
    .nxt       (state_d),
    .load_en   (state_en)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q      <= '0;
      state_q.mode <= PRV_M;
      state_q.mpp  <= PP_IDLE;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  assign mode_o = state_q.mode;
  assign mie_o  = state_q.mie;
  assign mpie_o = state_q.mpie;
  assign mpp_o  = state_q.mpp;
  assign sie_o  = state_q.sie;
  assign spie_o = state_q.spie;
  assign spp_o  = state_q.spp;
  assign mprv_o = state_q.mprv;

  // R2
  mret_stack_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mret_i && !trap_i) |=> (mode_o == $past(mpp_o)) && (mie_o == $past(mpie_o)) && mpie_o);

  // R3
  mret_pp_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mret_i && !trap_i) |=> (mpp_o == PP_IDLE));

  // R4
  mret_mprv_clr_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mret_i && !trap_i && mpp_o != PRV_M) |=> !mprv_o);

  // R4
  mret_mprv_keep_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mret_i && !trap_i && mpp_o == PRV_M) |=> (mprv_o == $past(mprv_o)));

  // R5
  sret_pop_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (HAS_S && sret_i && !mret_i && !trap_i) |=> !mprv_o && spie_o && !spp_o && (sie_o == $past(spie_o)));

  // R6
  trap_m_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (trap_i && trap_mode_i == PRV_M) |=> (mode_o == PRV_M) && !mie_o && (mpp_o == $past(mode_o)) && (mpie_o == $past(mie_o)));

  // R7
  mpp_legal_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mpp_o != PRV_RSV);

  // R7
  csr_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (csr_we_i && !trap_i && !mret_i && !sret_i) |=> $stable(mode_o));
endmodule

// File: tb/priv_ret_ctrl_test.sv
module priv_ret_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mret_i = 1'b0, sret_i = 1'b0, trap_i = 1'b0, csr_we_i = 1'b0;
  logic [1:0] trap_mode_i = 2'b00;
  logic [7:0] csr_wdata_i = 8'h00;
  logic [1:0] mode_o, mpp_o;
  logic       mie_o, mpie_o, sie_o, spie_o, spp_o, mprv_o;
  int         checks = 0;
  int         failures = 0;

  localparam logic [1:0] U = 2'b00, S = 2'b01, M = 2'b11;

  always #10 clk = ~clk;

  priv_ret_ctrl uut (
    .clk(clk), .rst_n(rst_n), .mret_i(mret_i), .sret_i(sret_i), .trap_i(trap_i),
    .trap_mode_i(trap_mode_i), .csr_we_i(csr_we_i), .csr_wdata_i(csr_wdata_i),
    .mode_o(mode_o), .mie_o(mie_o), .mpie_o(mpie_o), .mpp_o(mpp_o),
    .sie_o(sie_o), .spie_o(spie_o), .spp_o(spp_o), .mprv_o(mprv_o)
  );

  function automatic logic [9:0] ev(logic [1:0] md, logic pr, logic [1:0] pp,
                                    logic sp, logic mpi, logic spi, logic mi, logic si);
    return {md, pr, pp, sp, mpi, spi, mi, si};
  endfunction

  function automatic logic [7:0] wr(logic pr, logic [1:0] pp, logic sp,
                                    logic mpi, logic spi, logic mi, logic si);
    return {pr, pp, sp, mpi, spi, mi, si};
  endfunction

  task automatic check(input string req, input logic [9:0] exp);
    logic [9:0] act;
    act = {mode_o, mprv_o, mpp_o, spp_o, mpie_o, spie_o, mie_o, sie_o};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic m, input logic s, input logic t, input logic [1:0] tm,
                       input logic we, input logic [7:0] wd);
    @(negedge clk);
    mret_i = m; sret_i = s; trap_i = t; trap_mode_i = tm; csr_we_i = we; csr_wdata_i = wd;
    @(negedge clk);
    mret_i = 0; sret_i = 0; trap_i = 0; trap_mode_i = 2'b00; csr_we_i = 0; csr_wdata_i = 8'h00;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 reset", ev(M, 0, U, 0, 0, 0, 0, 0));
  endtask

  task automatic t_csr;
    pulse(0, 0, 0, U, 1, wr(1, S, 1, 1, 0, 0, 1));
    check("R7 csr load", ev(M, 1, S, 1, 1, 0, 0, 1));
    pulse(0, 0, 0, U, 1, wr(1, 2'b10, 1, 1, 1, 0, 1));
    check("R7 reserved mpp kept", ev(M, 1, S, 1, 1, 1, 0, 1));
  endtask

  task automatic t_mret_to_s;
    pulse(1, 0, 0, U, 0, 8'h00);
    check("R2 R3 R4 mret to S clears mprv", ev(S, 0, U, 1, 1, 1, 1, 1));
  endtask

  task automatic t_sret_to_u;
    pulse(0, 0, 0, U, 1, wr(1, U, 0, 1, 0, 1, 1));
    check("R7 csr keeps mode", ev(S, 1, U, 0, 1, 0, 1, 1));
    pulse(0, 1, 0, U, 0, 8'h00);
    check("R5 sret to U", ev(U, 0, U, 0, 1, 1, 1, 0));
  endtask

  task automatic t_trap_m;
    pulse(0, 0, 1, M, 0, 8'h00);
    check("R6 trap to M", ev(M, 0, U, 0, 1, 1, 0, 0));
  endtask

  task automatic t_mret_stay_m;
    pulse(0, 0, 0, U, 1, wr(1, M, 0, 0, 1, 1, 0));
    check("R7 csr mpp M", ev(M, 1, M, 0, 0, 1, 1, 0));
    pulse(1, 0, 0, U, 0, 8'h00);
    check("R4 mret to M keeps mprv", ev(M, 1, U, 0, 1, 1, 0, 0));
  endtask

  task automatic t_trap_s;
    pulse(0, 0, 0, U, 1, wr(0, U, 0, 1, 0, 0, 1));
    check("R7 csr setup", ev(M, 0, U, 0, 1, 0, 0, 1));
    pulse(0, 0, 1, S, 0, 8'h00);
    check("R6 trap to S", ev(S, 0, U, 1, 1, 1, 0, 0));
  endtask

  task automatic t_trap_vs_ret;
    pulse(1, 0, 1, M, 0, 8'h00);
    check("R8 trap beats mret", ev(M, 0, S, 1, 0, 1, 0, 0));
  endtask

  task automatic t_ret_vs_csr;
    pulse(1, 0, 0, U, 1, wr(1, M, 0, 1, 0, 1, 1));
    check("R9 mret beats csr write", ev(S, 0, U, 1, 1, 1, 0, 0));
  endtask

  task automatic t_mret_vs_sret;
    pulse(0, 0, 0, U, 1, wr(1, M, 0, 1, 0, 0, 1));
    check("R7 csr setup 2", ev(S, 1, M, 0, 1, 0, 0, 1));
    pulse(1, 1, 0, U, 0, 8'h00);
    check("R10 mret beats sret", ev(M, 1, U, 0, 1, 0, 1, 1));
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_csr();
    t_mret_to_s();
    t_sret_to_u();
    t_trap_m();
    t_mret_stay_m();
    t_trap_s();
    t_trap_vs_ret();
    t_ret_vs_csr();
    t_mret_vs_sret();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule